// File: doc/BRIEF.md
# PWM-Triggered Drive Strength Sequencer

This block sits between a pulse-width-modulated control input and a parallel gate-drive output stage built from eight binary-weighted groups of unit cells. It keeps two short programmable strength sequences, one used when the PWM input rises and one used when it falls. On each PWM transition it steps through the matching sequence, one 8-bit strength code per system clock, for eight clocks. Each code goes to the pull-up enable vector or the pull-down enable vector, depending on the PWM level. After the eighth code the last setting stays on the outputs until the next transition.

An external controller loads the sixteen codes through a word-write port: an address, a data byte and a write strobe. Writes are accepted only while the program-enable input is high. While that input is high, the enable outputs are forced to zero, so the drive stage is off during reprogramming. A code of zero selects no cells on either side, which leaves the output high impedance for that step. A new PWM transition that arrives while a sequence is still running abandons it and starts the other sequence from its first step.

Top module: `drive_seq_top`

## Requirements
- R1: While reset is asserted and after its release with no PWM transition, both `pu_en` and `pd_en` are 0x00.
- R2: A rising transition of `pwm_in` plays the turn-on sequence (addresses 0 to 7). Step 0 appears on `pu_en` after the third rising clock edge that follows the change. Steps 1 to 7 follow, one per clock edge.
- R3: A falling transition of `pwm_in` plays the turn-off sequence (addresses 8 to 15) on `pd_en`, with the same timing as R2.
- R4: The pull direction follows the PWM level that was detected. When that level is high, `pd_en` is 0x00; when it is low, `pu_en` is 0x00. `pu_en` and `pd_en` are never nonzero in the same cycle.
- R5: A stored code of 0x00 drives both outputs to 0x00 (high impedance) for that step. Codes 0x01 to 0xFF enable that many unit cells through bit weights 1 to 128.
- R6: After step 7, the outputs keep the step-7 value on every following clock until the next PWM transition.
- R7: A PWM transition during a running sequence restarts playback at step 0 of the sequence selected by the new transition, with the timing of R2.
- R8: Write address bit 3 selects the sequence (0 turn-on, 1 turn-off) and bits 2:0 select the step. A write takes effect at a clock edge where `wr_en` and `prog_en` are both high. A write made while `prog_en` is low changes no stored code.
- R9: From the first clock edge at which `prog_en` is sampled high, both outputs are 0x00. From the first edge at which it is sampled low again, the outputs return to the value that playback has reached.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Asynchronous PWM control input |
| prog_en | input | 1 | Programming mode: output disable and write permit |
| wr_en | input | 1 | Write strobe for the code store |
| wr_addr | input | 4 | Code address {sequence, step} |
| wr_data | input | 8 | Strength code to store |
| pu_en | output | 8 | Pull-up unit-cell group enables |
| pd_en | output | 8 | Pull-down unit-cell group enables |

## Verification
Two functions can land in the same cycle. A new PWM transition can arrive while an earlier sequence is mid-play, so the restart path and the step advance compete for the step counter. Programming mode can also begin or end while playback is stepping or holding. The bench provokes the first by reversing the PWM input a few clocks into a sequence, and it checks the two leftover old steps and then the full new sequence, cycle by cycle. It provokes the second by entering and leaving programming mode during the hold, and it checks that the outputs read zero and then return to the held code. Write codes and PWM directions are randomized, and the results are compared against a bench model of the code store.

// File: rtl/drive_seq_pkg.sv
package drive_seq_pkg;
  typedef enum logic {
    PULL_DN = 1'b0,
    PULL_UP = 1'b1
  } pull_dir_e;

  localparam logic SEQ_SEL_ON  = 1'b0;
  localparam logic SEQ_SEL_OFF = 1'b1;
endpackage

// File: rtl/pwm_edge_sync.sv
module pwm_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_async,
  output logic lvl,
  output logic edge_det
);
  logic [STAGES-1:0] sh_q, sh_n;
  logic              prev_q, prev_n;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_n = pwm_async;
    end else begin : g_chain
      always_comb sh_n = {sh_q[STAGES-2:0], pwm_async};
    end
  endgenerate

  always_comb prev_n = sh_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_n;
      prev_q <= prev_n;
    end
  end

  assign lvl      = sh_q[STAGES-1];
  assign edge_det = sh_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/seq_store.sv
module seq_store #(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned STEPS  = 8,
  localparam int unsigned STEP_W  = $clog2(STEPS),
  localparam int unsigned ADDR_W  = STEP_W + 1,
  localparam int unsigned ENTRIES = 2 * STEPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CODE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CODE_W-1:0] rd_data
);
  logic [CODE_W-1:0] mem_q [ENTRIES];

  generate
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic ce;
      always_comb ce = wr_en && (wr_addr == ADDR_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  mem_q[i] <= '0;
        else if (ce) mem_q[i] <= wr_data;
      end
    end
  endgenerate

  always_comb rd_data = mem_q[rd_addr];
endmodule

// File: rtl/step_ctrl.sv
module step_ctrl
  import drive_seq_pkg::*;
#(
  parameter int unsigned STEPS = 8,
  localparam int unsigned STEP_W = $clog2(STEPS),
  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              edge_det,
  input  logic              lvl,
  output logic              load,
  output logic              rd_sel,
  output logic [STEP_W-1:0] rd_step,
  output logic [STEP_W-1:0] step_q,
  output logic              running_q,
  output pull_dir_e         dir_q
);
  logic              sel_q, sel_n;
  logic [STEP_W-1:0] step_n;
  logic              run_n;
  pull_dir_e         dir_n;

  always_comb begin
    sel_n  = sel_q;
    step_n = step_q;
    run_n  = running_q;
    dir_n  = dir_q;
    load   = 1'b0;
    if (edge_det) begin
      sel_n  = lvl ? SEQ_SEL_ON : SEQ_SEL_OFF;
      dir_n  = lvl ? PULL_UP : PULL_DN;
      step_n = '0;
      run_n  = 1'b1;
      load   = 1'b1;
    end else if (running_q && (step_q != LAST)) begin
      step_n = step_q + 1'b1;
      load   = 1'b1;
    end else begin
      run_n  = 1'b0;
    end
  end

  assign rd_sel  = sel_n;
  assign rd_step = step_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= SEQ_SEL_OFF;
      step_q    <= LAST;
      running_q <= 1'b0;
      dir_q     <= PULL_DN;
    end else begin
      sel_q     <= sel_n;
      step_q    <= step_n;
      running_q <= run_n;
      dir_q     <= dir_n;
    end
  end
endmodule

// File: rtl/drive_seq_top.sv
module drive_seq_top
  import drive_seq_pkg::*;
#(
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned STEPS       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned STEP_W = $clog2(STEPS),
  localparam int unsigned ADDR_W = STEP_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_in,
  input  logic              prog_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CODE_W-1:0] wr_data,
  output logic [CODE_W-1:0] pu_en,
  output logic [CODE_W-1:0] pd_en
);
  logic              lvl, edge_det, load, rd_sel;
  logic [STEP_W-1:0] rd_step, step_q;
  logic              running_q;
  pull_dir_e         dir_q;
  logic [CODE_W-1:0] rd_data, code_q, code_n;
  logic              en_q, en_n;
  logic [CODE_W-1:0] pu_raw, pd_raw;

  pwm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pwm_async(pwm_in),
    .lvl(lvl), .edge_det(edge_det)
  );

  step_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .edge_det(edge_det), .lvl(lvl),
    .load(load), .rd_sel(rd_sel), .rd_step(rd_step),
    .step_q(step_q), .running_q(running_q), .dir_q(dir_q)
  );

  seq_store #(.CODE_W(CODE_W), .STEPS(STEPS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en && prog_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr({rd_sel, rd_step}), .rd_data(rd_data)
  );

  always_comb begin
    code_n = load ? rd_data : code_q;
    en_n   = !prog_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      en_q   <= 1'b0;
    end else begin
      code_q <= code_n;
      en_q   <= en_n;
    end
  end

  always_comb begin
    pu_raw = (dir_q == PULL_UP) ? code_q : '0;
    pd_raw = (dir_q == PULL_DN) ? code_q : '0;
    if (!en_q || ((pu_raw != '0) && (pd_raw != '0))) begin
      pu_en = '0;
      pd_en = '0;
    end else begin
      pu_en = pu_raw;
      pd_en = pd_raw;
    end
  end
endmodule

// File: rtl/drive_seq_chk.sv
module drive_seq_chk #(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned STEPS  = 8,
  localparam int unsigned STEP_W = $clog2(STEPS),
  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prog_en,
  input logic [CODE_W-1:0] pu_en,
  input logic [CODE_W-1:0] pd_en,
  input logic              edge_det,
  input logic              running,
  input logic [STEP_W-1:0] step
);
  // R4
  no_both_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((pu_en != '0) && (pd_en != '0)));

  // R9
  prog_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(prog_en) |-> ((pu_en == '0) && (pd_en == '0)));

  // R7
  edge_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_det |=> (step == '0) && running);

  // R2
  step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !edge_det && (step != LAST)) |=> (step == STEP_W'($past(step) + 1'b1)));

  // R6
  final_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !edge_det && !prog_en && !$past(prog_en)) |=> ($stable(pu_en) && $stable(pd_en)));
endmodule

bind drive_seq_top drive_seq_chk #(.CODE_W(CODE_W), .STEPS(STEPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .pu_en(pu_en), .pd_en(pd_en),
  .edge_det(edge_det), .running(running_q), .step(step_q)
);

// File: tb/drive_seq_top_tb.sv
module drive_seq_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwm_in = 1'b0;
  logic       prog_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] pu_en, pd_en;

  int         checks = 0;
  int         errors = 0;
  logic       done = 1'b0;
  logic [7:0] m [16];
  logic [7:0] last_code = '0;
  logic       cur_lvl = 1'b0;

  always #4 clk = ~clk;

  drive_seq_top u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .prog_en(prog_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pu_en(pu_en), .pd_en(pd_en)
  );

  function automatic logic [7:0] exp_pu(logic lvl, logic [7:0] code);
    return lvl ? code : 8'h00;
  endfunction

  function automatic logic [7:0] exp_pd(logic lvl, logic [7:0] code);
    return lvl ? 8'h00 : code;
  endfunction

  task automatic chk(string tag, logic lvl, logic [7:0] code);
    logic [7:0] ep, ed;
    ep = exp_pu(lvl, code);
    ed = exp_pd(lvl, code);
    checks++;
    if (pu_en !== ep || pd_en !== ed) begin
      errors++;
      $display("FAIL %s pu=%h pd=%h expected pu=%h pd=%h", tag, pu_en, pd_en, ep, ed);
    end
  endtask

  function automatic string step_tag(logic lvl, logic [7:0] code);
    if (code == 8'h00) return "R5";
    return lvl ? "R2" : "R3";
  endfunction

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (prog_en) m[a] = d;
  endtask

  task automatic reprogram(int n);
    @(negedge clk);
    prog_en = 1'b1;
    @(posedge clk); #1;
    chk("R9", 1'b0, 8'h00);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
      wr(4'($urandom), d);
    end
    @(negedge clk);
    prog_en = 1'b0;
    @(posedge clk); #1;
    chk("R9", cur_lvl, last_code);
  endtask

  task automatic play(logic lvl);
    @(negedge clk);
    pwm_in = lvl;
    cur_lvl = lvl;
    repeat (3) @(posedge clk);
    #1;
    for (int k = 0; k < 8; k++) begin
      logic [7:0] c;
      if (k > 0) begin @(posedge clk); #1; end
      c = m[{~lvl, 3'(k)}];
      chk(step_tag(lvl, c), lvl, c);
    end
    last_code = m[{~lvl, 3'd7}];
    for (int h = 0; h < 3; h++) begin
      @(posedge clk); #1;
      chk("R6", lvl, last_code);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) m[i] = 8'h00;
    repeat (2) @(posedge clk);
    #1;
    chk("R1", 1'b0, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", 1'b0, 8'h00);

    // R8: load both sequences with distinct codes, one hi-Z step each
    @(negedge clk);
    prog_en = 1'b1;
    for (int i = 0; i < 16; i++) wr(4'(i), 8'((i * 37 + 5) & 8'hFF));
    wr(4'd3, 8'h00);
    wr(4'd12, 8'h00);
    wr(4'd7, 8'hFF);
    wr(4'd15, 8'h01);
    @(negedge clk);
    prog_en = 1'b0;
    @(posedge clk); #1;
    chk("R1", 1'b0, 8'h00);

    play(1'b1);
    play(1'b0);

    // R8: write with prog_en low is ignored
    wr(4'd0, 8'hA5);
    wr(4'd8, 8'h5A);
    play(1'b1);
    play(1'b0);

    // R7: reverse PWM mid-sequence
    @(negedge clk);
    pwm_in = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R7", 1'b1, m[0]);
    for (int k = 1; k < 3; k++) begin @(posedge clk); #1; chk("R7", 1'b1, m[k]); end
    @(negedge clk);
    pwm_in = 1'b0;
    cur_lvl = 1'b0;
    for (int k = 3; k < 5; k++) begin @(posedge clk); #1; chk("R7", 1'b1, m[k]); end
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); #1;
      chk("R7", 1'b0, m[{1'b1, 3'(k)}]);
    end
    last_code = m[15];
    @(posedge clk); #1;
    chk("R6", 1'b0, last_code);

    // R9: programming mode during hold
    reprogram(0);

    // random rounds
    for (int r = 0; r < 40; r++) begin
      if ($urandom % 2 == 0) reprogram(1 + int'($urandom % 4));
      play(~cur_lvl);
      repeat (int'($urandom % 5)) @(posedge clk);
      #1;
      chk("R6", cur_lvl, last_code);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule